// File: doc/BRIEF.md
# Unidirectional Multiplexer Routing Switch Box

This block is one routing junction of a synthesizable coarse-grain reconfigurable array. It sits where four channels meet: north, east, south and west. Each channel carries a group of single-bit tracks and a group of multi-bit word tracks. Every connection runs one way only. Each output track is fed by one 2-to-1 multiplexer that picks one of two incoming tracks with the same index. An enable bit can park the output at zero.

Word tracks are switched as whole buses, so all of their bits follow one choice. Even-indexed tracks use one switch pattern and odd-indexed tracks use its mirror. Together the two patterns let a signal turn in every direction across neighbouring indices.

The routing choices are held in flip-flops that form one serial scan chain. It is loaded one bit per clock and can be daisy-chained to the next box. The track outputs are combinational functions of the track inputs and the stored configuration. This data path is a plain wire-level route with no valid/ready handshake: a switch box forwards levels and cannot apply back-pressure.

Top module: `uni_switch_box`

## Requirements
- R1: When reset is asserted (rst_n low, asynchronous), every configuration bit is cleared. From then until new configuration is shifted in, every track output reads 0 whatever the inputs are, and cfg_out reads 0.
- R2: Each output has an enable bit. When that bit is 0 the output is 0 on every bit, whatever its inputs and its select bit are.
- R3: An even track index (counted within its group, bit or word) uses the first pattern. With sel=0 / sel=1: north out = east / west in; east out = north / west in; south out = west / east in; west out = south / east in.
- R4: An odd track index uses the mirrored pattern. With sel=0 / sel=1: north out = west / south in; east out = west / south in; south out = east / north in; west out = north / east in.
- R5: Disjoint connectivity: output track i of a group depends only on input track i of the same group on the other sides, and on its own configuration byte.
- R6: A word track is switched as a whole. All WORD_W bits of the output equal the corresponding bits of the same selected input word.
- R7: Configuration layout and shifting. Each track t owns chain bits [8t+7:8t]. Bit tracks come first (t = 0..N_BIT-1), then word tracks (t = N_BIT + j). Within a byte, the bit pairs for north, east, south and west sit at bits [1:0], [3:2], [5:4] and [7:6], with the select in the lower bit and the enable in the upper bit of each pair. While cfg_shift is high, each rising clock moves the chain one place toward its top bit and loads cfg_in into bit 0. cfg_out always shows the top bit, so the first bit shifted in lands in the top bit after exactly LEN shifts.
- R8: While cfg_shift is low, the configuration holds: toggling cfg_in changes neither the track outputs nor cfg_out.
- R9: Track outputs follow track-input changes within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the configuration |
| cfg_shift | input | 1 | Shift enable for the configuration chain |
| cfg_in | input | 1 | Serial configuration input |
| cfg_out | output | 1 | Top bit of the chain, for daisy-chaining |
| n_bit_in | input | N_BIT | North single-bit tracks in |
| e_bit_in | input | N_BIT | East single-bit tracks in |
| s_bit_in | input | N_BIT | South single-bit tracks in |
| w_bit_in | input | N_BIT | West single-bit tracks in |
| n_word_in | input | N_WORD*WORD_W | North word tracks in, track j at bits [j*WORD_W +: WORD_W] |
| e_word_in | input | N_WORD*WORD_W | East word tracks in |
| s_word_in | input | N_WORD*WORD_W | South word tracks in |
| w_word_in | input | N_WORD*WORD_W | West word tracks in |
| n_bit_out | output | N_BIT | North single-bit tracks out |
| e_bit_out | output | N_BIT | East single-bit tracks out |
| s_bit_out | output | N_BIT | South single-bit tracks out |
| w_bit_out | output | N_BIT | West single-bit tracks out |
| n_word_out | output | N_WORD*WORD_W | North word tracks out |
| e_word_out | output | N_WORD*WORD_W | East word tracks out |
| s_word_out | output | N_WORD*WORD_W | South word tracks out |
| w_word_out | output | N_WORD*WORD_W | West word tracks out |

## Verification
The bench builds the box with N_BIT=4, N_WORD=2 and WORD_W=4, which gives a 48-bit chain. That is short enough to load the whole chain once per scenario. It still has two even and two odd bit tracks, plus one word track of each parity, so both switch patterns appear in both groups. It also puts a bit-to-word boundary inside the chain, which checks that the byte layout carries across groups. The default 12/12/4 build has the same structure and is only elaborated, not exercised.

// File: rtl/usb_pkg.sv
package usb_pkg;
  localparam int SIDES       = 4;
  localparam int OUT_CFG_W   = 2;
  localparam int TRACK_CFG_W = SIDES * OUT_CFG_W;

  typedef enum int {SIDE_N = 0, SIDE_E = 1, SIDE_S = 2, SIDE_W = 3} side_e;

  function automatic int sel_pos(side_e s);
    return int'(s) * OUT_CFG_W;
  endfunction

  function automatic int en_pos(side_e s);
    return int'(s) * OUT_CFG_W + 1;
  endfunction
endpackage

// File: rtl/usb_cfg_chain.sv
module usb_cfg_chain #(
  parameter int LEN = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           ser_in,
  output logic [LEN-1:0] q,
  output logic           ser_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (shift_en) q <= {q[LEN-2:0], ser_in};
  end

  assign ser_out = q[LEN-1];
endmodule

// File: rtl/usb_out_mux.sv
module usb_out_mux #(
  parameter int W = 1
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sel,
  input  logic         en,
  output logic [W-1:0] y
);
  always_comb begin
    if (!en)     y = '0;
    else if (sel) y = b;
    else          y = a;
  end
endmodule

// File: rtl/usb_track_sw.sv
module usb_track_sw
  import usb_pkg::*;
#(
  parameter int W   = 1,
  parameter bit ODD = 1'b0
) (
  input  logic [W-1:0]             n_i,
  input  logic [W-1:0]             e_i,
  input  logic [W-1:0]             s_i,
  input  logic [W-1:0]             w_i,
  input  logic [TRACK_CFG_W-1:0]   cfg,
  output logic [W-1:0]             n_o,
  output logic [W-1:0]             e_o,
  output logic [W-1:0]             s_o,
  output logic [W-1:0]             w_o
);
  localparam int NS = sel_pos(SIDE_N), NE = en_pos(SIDE_N);
  localparam int ES = sel_pos(SIDE_E), EE = en_pos(SIDE_E);
  localparam int SS = sel_pos(SIDE_S), SE = en_pos(SIDE_S);
  localparam int WS = sel_pos(SIDE_W), WE = en_pos(SIDE_W);

  generate
    if (!ODD) begin : g_type_a
      usb_out_mux #(.W(W)) u_n (.a(e_i), .b(w_i), .sel(cfg[NS]), .en(cfg[NE]), .y(n_o));
      usb_out_mux #(.W(W)) u_e (.a(n_i), .b(w_i), .sel(cfg[ES]), .en(cfg[EE]), .y(e_o));
      usb_out_mux #(.W(W)) u_s (.a(w_i), .b(e_i), .sel(cfg[SS]), .en(cfg[SE]), .y(s_o));
      usb_out_mux #(.W(W)) u_w (.a(s_i), .b(e_i), .sel(cfg[WS]), .en(cfg[WE]), .y(w_o));
    end else begin : g_type_b
      usb_out_mux #(.W(W)) u_n (.a(w_i), .b(s_i), .sel(cfg[NS]), .en(cfg[NE]), .y(n_o));
      usb_out_mux #(.W(W)) u_e (.a(w_i), .b(s_i), .sel(cfg[ES]), .en(cfg[EE]), .y(e_o));
      usb_out_mux #(.W(W)) u_s (.a(e_i), .b(n_i), .sel(cfg[SS]), .en(cfg[SE]), .y(s_o));
      usb_out_mux #(.W(W)) u_w (.a(n_i), .b(e_i), .sel(cfg[WS]), .en(cfg[WE]), .y(w_o));
    end
  endgenerate
endmodule

// File: rtl/uni_switch_box.sv
module uni_switch_box
  import usb_pkg::*;
#(
  parameter int N_BIT  = 12,
  parameter int N_WORD = 12,
  parameter int WORD_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_shift,
  input  logic                       cfg_in,
  output logic                       cfg_out,
  input  logic [N_BIT-1:0]           n_bit_in,
  input  logic [N_BIT-1:0]           e_bit_in,
  input  logic [N_BIT-1:0]           s_bit_in,
  input  logic [N_BIT-1:0]           w_bit_in,
  input  logic [N_WORD*WORD_W-1:0]   n_word_in,
  input  logic [N_WORD*WORD_W-1:0]   e_word_in,
  input  logic [N_WORD*WORD_W-1:0]   s_word_in,
  input  logic [N_WORD*WORD_W-1:0]   w_word_in,
  output logic [N_BIT-1:0]           n_bit_out,
  output logic [N_BIT-1:0]           e_bit_out,
  output logic [N_BIT-1:0]           s_bit_out,
  output logic [N_BIT-1:0]           w_bit_out,
  output logic [N_WORD*WORD_W-1:0]   n_word_out,
  output logic [N_WORD*WORD_W-1:0]   e_word_out,
  output logic [N_WORD*WORD_W-1:0]   s_word_out,
  output logic [N_WORD*WORD_W-1:0]   w_word_out
);
  localparam int TRACKS  = N_BIT + N_WORD;
  localparam int CFG_LEN = TRACKS * TRACK_CFG_W;

  logic [CFG_LEN-1:0] cfg_q;

  usb_cfg_chain #(.LEN(CFG_LEN)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (cfg_shift),
    .ser_in   (cfg_in),
    .q        (cfg_q),
    .ser_out  (cfg_out)
  );

  genvar gi;
  generate
    for (gi = 0; gi < N_BIT; gi++) begin : g_bit
      usb_track_sw #(.W(1), .ODD(gi % 2 == 1)) u_sw (
        .n_i (n_bit_in[gi]), .e_i (e_bit_in[gi]),
        .s_i (s_bit_in[gi]), .w_i (w_bit_in[gi]),
        .cfg (cfg_q[gi*TRACK_CFG_W +: TRACK_CFG_W]),
        .n_o (n_bit_out[gi]), .e_o (e_bit_out[gi]),
        .s_o (s_bit_out[gi]), .w_o (w_bit_out[gi])
      );
    end
    for (gi = 0; gi < N_WORD; gi++) begin : g_word
      usb_track_sw #(.W(WORD_W), .ODD(gi % 2 == 1)) u_sw (
        .n_i (n_word_in[gi*WORD_W +: WORD_W]), .e_i (e_word_in[gi*WORD_W +: WORD_W]),
        .s_i (s_word_in[gi*WORD_W +: WORD_W]), .w_i (w_word_in[gi*WORD_W +: WORD_W]),
        .cfg (cfg_q[(N_BIT+gi)*TRACK_CFG_W +: TRACK_CFG_W]),
        .n_o (n_word_out[gi*WORD_W +: WORD_W]), .e_o (e_word_out[gi*WORD_W +: WORD_W]),
        .s_o (s_word_out[gi*WORD_W +: WORD_W]), .w_o (w_word_out[gi*WORD_W +: WORD_W])
      );
    end
  endgenerate
endmodule

// File: rtl/uni_switch_box_chk.sv
module uni_switch_box_chk #(
  parameter int N_BIT  = 12,
  parameter int N_WORD = 12,
  parameter int WORD_W = 4,
  parameter int LEN    = 192
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_shift,
  input logic [LEN-1:0]           cfg_q,
  input logic                     cfg_out,
  input logic [N_BIT-1:0]         e_bit_in,
  input logic [N_BIT-1:0]         s_bit_in,
  input logic [N_BIT-1:0]         w_bit_in,
  input logic [N_BIT-1:0]         n_bit_out,
  input logic [N_BIT-1:0]         e_bit_out,
  input logic [N_BIT-1:0]         s_bit_out,
  input logic [N_BIT-1:0]         w_bit_out,
  input logic [N_WORD*WORD_W-1:0] n_word_out
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cfg_out == 1'b0 && n_bit_out == '0 && e_bit_out == '0 &&
                      s_bit_out == '0 && w_bit_out == '0 && n_word_out == '0)); // R1

  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_shift |=> cfg_out == $past(cfg_q[LEN-2])); // R7

  AST_HOLD_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_shift |=> $stable(cfg_out)); // R8

  genvar gt;
  generate
    for (gt = 0; gt < N_BIT; gt++) begin : g_bt
      AST_N_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q[gt*8+1] |-> n_bit_out[gt] == 1'b0); // R2
      AST_S_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q[gt*8+5] |-> s_bit_out[gt] == 1'b0); // R2
      if (gt % 2 == 0) begin : g_even
        AST_EVEN_N_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
          cfg_q[gt*8+1] |-> n_bit_out[gt] == (cfg_q[gt*8] ? w_bit_in[gt] : e_bit_in[gt])); // R3
        AST_EVEN_E_OFF: assert property (@(posedge clk) disable iff (!rst_n)
          !cfg_q[gt*8+3] |-> e_bit_out[gt] == 1'b0); // R2
      end else begin : g_odd
        AST_ODD_N_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
          cfg_q[gt*8+1] |-> n_bit_out[gt] == (cfg_q[gt*8] ? s_bit_in[gt] : w_bit_in[gt])); // R4
        AST_ODD_W_OFF: assert property (@(posedge clk) disable iff (!rst_n)
          !cfg_q[gt*8+7] |-> w_bit_out[gt] == 1'b0); // R2
      end
    end
  endgenerate
endmodule

bind uni_switch_box uni_switch_box_chk #(
  .N_BIT(N_BIT), .N_WORD(N_WORD), .WORD_W(WORD_W), .LEN(CFG_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_q(cfg_q), .cfg_out(cfg_out),
  .e_bit_in(e_bit_in), .s_bit_in(s_bit_in), .w_bit_in(w_bit_in),
  .n_bit_out(n_bit_out), .e_bit_out(e_bit_out), .s_bit_out(s_bit_out),
  .w_bit_out(w_bit_out), .n_word_out(n_word_out)
);

// File: tb/uni_switch_box_test.sv
module uni_switch_box_test;
  localparam int NB = 4;
  localparam int NW = 2;
  localparam int WW = 4;
  localparam int L  = (NB + NW) * 8;
  localparam int NWB = NW * WW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_shift = 1'b0;
  logic cfg_in = 1'b0;
  logic cfg_out;
  logic [NB-1:0]  bi [4];
  logic [NWB-1:0] wi [4];
  logic [NB-1:0]  bo [4];
  logic [NWB-1:0] wo [4];

  int n_checks = 0;
  int n_fail = 0;
  logic [L-1:0] img = '0;

  always #10 clk = ~clk;

  initial begin
    for (int s = 0; s < 4; s++) begin bi[s] = '0; wi[s] = '0; end
  end

  uni_switch_box #(.N_BIT(NB), .N_WORD(NW), .WORD_W(WW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_in(cfg_in), .cfg_out(cfg_out),
    .n_bit_in(bi[0]), .e_bit_in(bi[1]), .s_bit_in(bi[2]), .w_bit_in(bi[3]),
    .n_word_in(wi[0]), .e_word_in(wi[1]), .s_word_in(wi[2]), .w_word_in(wi[3]),
    .n_bit_out(bo[0]), .e_bit_out(bo[1]), .s_bit_out(bo[2]), .w_bit_out(bo[3]),
    .n_word_out(wo[0]), .e_word_out(wo[1]), .s_word_out(wo[2]), .w_word_out(wo[3])
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] in_of(int side, bit is_word, int t);
    if (is_word) return wi[side][t*WW +: WW];
    return {{(WW-1){1'b0}}, bi[side][t]};
  endfunction

  // reference: side order N=0,E=1,S=2,W=3
  function automatic logic [WW-1:0] model(int side, bit is_word, int t);
    int base = (is_word ? NB + t : t) * 8;
    logic sel = img[base + 2*side];
    logic en  = img[base + 2*side + 1];
    int src;
    if (!en) return '0;
    if (t % 2 == 0) begin
      case (side)
        0: src = sel ? 3 : 1;
        1: src = sel ? 3 : 0;
        2: src = sel ? 1 : 3;
        default: src = sel ? 1 : 2;
      endcase
    end else begin
      case (side)
        0: src = sel ? 2 : 3;
        1: src = sel ? 2 : 3;
        2: src = sel ? 0 : 1;
        default: src = sel ? 1 : 0;
      endcase
    end
    return in_of(src, is_word, t);
  endfunction

  task automatic check_all(string req);
    for (int s = 0; s < 4; s++) begin
      for (int t = 0; t < NB; t++) chk(req, 32'(bo[s][t]), 32'(model(s, 1'b0, t)));
      for (int t = 0; t < NW; t++) chk(req, 32'(wo[s][t*WW +: WW]), 32'(model(s, 1'b1, t)));
    end
  endtask

  task automatic set_out(int track, int side, bit en, bit sel);
    img[track*8 + 2*side]     = sel;
    img[track*8 + 2*side + 1] = en;
  endtask

  task automatic load_img();
    for (int k = L - 1; k >= 0; k--) begin
      cfg_in = img[k];
      cfg_shift = 1'b1;
      @(posedge clk); #1;
    end
    cfg_shift = 1'b0;
    cfg_in = 1'b0;
    #1;
  endtask

  task automatic drive_inputs(int seed);
    for (int s = 0; s < 4; s++) begin
      bi[s] = NB'(seed * 7 + s * 5 + 3);
      wi[s] = NWB'(seed * 37 + s * 91 + 17);
    end
    #1;
  endtask

  task automatic t_reset();
    drive_inputs(5);
    check_all("R1 outputs zero after reset");
    chk("R1 cfg_out after reset", 32'(cfg_out), 32'd0);
  endtask

  task automatic t_even_routes();
    img = '0;
    for (int t = 0; t < NB + NW; t++)
      for (int s = 0; s < 4; s++) set_out(t, s, 1'b1, 1'b0);
    load_img();
    chk("R7 cfg_out after load", 32'(cfg_out), 32'(img[L-1]));
    for (int p = 0; p < 3; p++) begin
      drive_inputs(p + 11);
      check_all("R3/R4 routing sel=0");
    end
  endtask

  task automatic t_odd_routes();
    img = '0;
    for (int t = 0; t < NB + NW; t++)
      for (int s = 0; s < 4; s++) set_out(t, s, 1'b1, 1'b1);
    load_img();
    for (int p = 0; p < 3; p++) begin
      drive_inputs(p + 21);
      check_all("R3/R4 routing sel=1");
    end
    // explicit even/odd single probes
    bi[1] = 4'b0000; bi[3] = 4'b0001; bi[2] = 4'b0010; #1;
    chk("R3 even N takes W when sel=1", 32'(bo[0][0]), 32'd1);
    chk("R4 odd N takes S when sel=1", 32'(bo[0][1]), 32'd1);
  endtask

  task automatic t_disable();
    img = '0;
    for (int t = 0; t < NB + NW; t++)
      for (int s = 0; s < 4; s++) set_out(t, s, (t + s) % 2 == 0, 1'b1);
    load_img();
    for (int s = 0; s < 4; s++) begin bi[s] = '1; wi[s] = '1; end
    #1;
    check_all("R2 disabled outputs zero");
    chk("R2 north bit1 disabled", 32'(bo[0][1]), 32'd0);
  endtask

  task automatic t_word();
    img = '0;
    set_out(NB, 0, 1'b1, 1'b0);
    set_out(NB + 1, 2, 1'b1, 1'b1);
    load_img();
    drive_inputs(0);
    wi[1] = 8'hA5; wi[0] = 8'h3C; #1;
    chk("R6 word0 north from east", 32'(wo[0][WW-1:0]), 32'h5);
    chk("R6 word1 south from north", 32'(wo[2][2*WW-1:WW]), 32'h3);
    check_all("R6 word tracks whole");
  endtask

  task automatic t_disjoint();
    img = '0;
    set_out(2, 1, 1'b1, 1'b0);
    load_img();
    for (int s = 0; s < 4; s++) begin bi[s] = 4'b1011; wi[s] = '1; end
    bi[0] = 4'b1011; #1;
    chk("R5 east bit2 tracks north bit2 only", 32'(bo[1]), 32'b0000);
    bi[0] = 4'b0100; #1;
    chk("R5 east bit2 follows north bit2", 32'(bo[1]), 32'b0100);
    check_all("R5 disjoint");
  endtask

  task automatic t_shift_out();
    img = '0;
    for (int k = 0; k < L; k += 3) img[k] = 1'b1;
    img[L-1] = 1'b1; img[L-2] = 1'b0; img[L-3] = 1'b1; img[L-4] = 1'b1;
    load_img();
    drive_inputs(9);
    check_all("R7 layout after load");
    for (int k = 0; k < 3; k++) begin
      chk("R7 cfg_out walks chain", 32'(cfg_out), 32'(img[L-1-k]));
      cfg_shift = 1'b1; cfg_in = 1'b0;
      @(posedge clk); #1;
    end
    cfg_shift = 1'b0;
    chk("R7 cfg_out after 3 extra shifts", 32'(cfg_out), 32'(img[L-4]));
  endtask

  task automatic t_hold();
    logic [NB-1:0] snap;
    logic so;
    img = '0;
    for (int s = 0; s < 4; s++) set_out(0, s, 1'b1, 1'b0);
    load_img();
    drive_inputs(3);
    snap = bo[0]; so = cfg_out;
    for (int k = 0; k < 6; k++) begin
      cfg_in = k[0];
      @(posedge clk); #1;
    end
    check_all("R8 config held");
    chk("R8 north held", 32'(bo[0]), 32'(snap));
    chk("R8 cfg_out held", 32'(cfg_out), 32'(so));
  endtask

  task automatic t_comb();
    img = '0;
    set_out(0, 0, 1'b1, 1'b0);
    load_img();
    @(negedge clk);
    bi[1] = 4'b0001; #2;
    chk("R9 same-cycle response high", 32'(bo[0][0]), 32'd1);
    bi[1] = 4'b0000; #2;
    chk("R9 same-cycle response low", 32'(bo[0][0]), 32'd0);
  endtask

  task automatic t_reset_mid();
    rst_n = 1'b0; #3;
    img = '0;
    drive_inputs(7);
    check_all("R1 async reset clears config");
    @(negedge clk); rst_n = 1'b1; #1;
  endtask

  initial begin
    #(20ns * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1;
    repeat (2) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1'b1; #1;
    t_reset();
    t_even_routes();
    t_odd_routes();
    t_disable();
    t_word();
    t_disjoint();
    t_shift_out();
    t_hold();
    t_comb();
    t_reset_mid();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule